// File: doc/BRIEF.md
# Three-Operand Integer Adder with Halfword Modes

This block adds three 32-bit integer operands in a single registered step. Each operand can be replaced by its two's complement. When the register-form flag is set, each operand can also be narrowed to its low or high 16-bit half, zero-extended, before that negation. The sum of the first two operands is kept to 33 bits.

In register form, that partial sum can be moved by 16 bit positions to the right or to the left before the third operand is added. The shift is logical. A right move carries the bit-32 carry of the partial sum into bit 16 of the shifted value.

The unit takes one request per cycle, marked by an input valid strobe. The result and an input valid flag appear on the next clock edge. Four condition flags come with the result: zero, sign, carry and signed overflow. They change only when the request asks for them.

Top module: `add3_unit`

## Requirements
- R1: While reset is asserted and after it is released with no request, out_valid, result and all four flags are 0.
- R2: out_valid is 1 in exactly the cycle after a cycle with in_valid high. After a cycle with in_valid low, out_valid is 0 and result keeps its previous value.
- R3: With reg_form=1, each operand's height code selects the operand as follows: 0 = full word, 1 = bits 15:0 zero-extended, 2 = bits 31:16 zero-extended, 3 = full word.
- R4: With reg_form=0, the height codes have no effect and all operands are used as full words.
- R5: Each operand's negate bit replaces that operand with its 32-bit two's complement. Negation is applied after height selection.
- R6: With reg_form=1, shift_mode selects what happens to the 33-bit sum of the first two prepared operands before the third is added: 1 = logical right shift by 16, which puts the partial-sum carry into bit 16; 2 = logical left shift by 16, truncated to 32 bits; 0 or 3 = low 32 bits unchanged.
- R7: With reg_form=0, shift_mode has no effect and the result is the plain 32-bit sum of the three prepared operands.
- R8: When flags are updated, flag_zero is 1 exactly when result is 0, and flag_sign equals result bit 31.
- R9: When flags are updated, flag_carry is the carry out of the final 32-bit addition (shifted partial sum plus third operand). flag_ovf is the signed overflow of that same addition.
- R10: Flags are updated only on a cycle with both in_valid and cc_en high. Otherwise they keep their values, even when result changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request strobe |
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand |
| op_c | input | 32 | Third operand |
| neg_a | input | 1 | Negate first operand |
| neg_b | input | 1 | Negate second operand |
| neg_c | input | 1 | Negate third operand |
| height_a | input | 2 | Height code, first operand |
| height_b | input | 2 | Height code, second operand |
| height_c | input | 2 | Height code, third operand |
| shift_mode | input | 2 | Partial-sum shift code |
| reg_form | input | 1 | Register form: enables height and shift codes |
| cc_en | input | 1 | Condition-flag update enable |
| out_valid | output | 1 | Result valid, one cycle after the request |
| result | output | 32 | Registered sum |
| flag_zero | output | 1 | Result is zero |
| flag_sign | output | 1 | Result bit 31 |
| flag_carry | output | 1 | Carry out of the final addition |
| flag_ovf | output | 1 | Signed overflow of the final addition |

## Verification
Some behaviours are checked by the assertions on every cycle:
- the timing of the output strobe;
- result holding while no request is made;
- flags holding unless an update is requested;
- zero and sign agreeing with the registered result;
- in the non-register form, the result matching the plain sum of the negated operands.

The height codes, the shift modes (in particular the carry brought into bit 16 by a right shift), and the carry and overflow values can only be shown by the bench. It sweeps every height, negate and shift combination in both forms over boundary operand patterns.

// File: rtl/add3_pkg.sv
package add3_pkg;

  typedef enum logic [1:0] {
    HT_FULL = 2'd0,
    HT_LO   = 2'd1,
    HT_HI   = 2'd2,
    HT_RSVD = 2'd3
  } height_e;

  typedef enum logic [1:0] {
    SH_NONE  = 2'd0,
    SH_RIGHT = 2'd1,
    SH_LEFT  = 2'd2,
    SH_RSVD  = 2'd3
  } shift_e;

  typedef struct packed {
    logic zero;
    logic sign;
    logic carry;
    logic ovf;
  } cond_flags_t;

  localparam int unsigned NUM_OPND = 3;

endpackage

// File: rtl/add3_operand_prep.sv
module add3_operand_prep
  import add3_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic [DATA_W-1:0] opnd,
  input  logic [1:0]        height,
  input  logic              neg,
  input  logic              reg_form,
  output logic [DATA_W-1:0] prepped
);

  localparam int unsigned HALF_W = DATA_W / 2;

  logic [DATA_W-1:0] narrowed;

  // Height selection (register form only)
  always_comb begin
    narrowed = opnd;
    if (reg_form) begin
      case (height)
        HT_LO:   narrowed = {{HALF_W{1'b0}}, opnd[HALF_W-1:0]};
        HT_HI:   narrowed = {{HALF_W{1'b0}}, opnd[DATA_W-1:HALF_W]};
        default: narrowed = opnd;
      endcase
    end
  end

  // Two's complement after narrowing
  always_comb begin
    if (neg) begin
      prepped = ~narrowed + DATA_W'(1);
    end else begin
      prepped = narrowed;
    end
  end

endmodule

// File: rtl/add3_sum_core.sv
module add3_sum_core
  import add3_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic [DATA_W-1:0] x_in,
  input  logic [DATA_W-1:0] y_in,
  input  logic [DATA_W-1:0] z_in,
  input  logic [1:0]        shift_mode,
  input  logic              reg_form,
  output logic [DATA_W-1:0] sum_out,
  output logic              carry_out,
  output logic              ovf_out
);

  localparam int unsigned HALF_W = DATA_W / 2;

  logic [DATA_W:0]   partial;
  logic [DATA_W-1:0] shifted;
  logic [DATA_W:0]   total;

  // Partial sum kept one bit wider so a right move keeps its carry
  always_comb begin
    partial = {1'b0, x_in} + {1'b0, y_in};
  end

  always_comb begin
    shifted = partial[DATA_W-1:0];
    if (reg_form) begin
      case (shift_mode)
        SH_RIGHT: shifted = DATA_W'(partial >> HALF_W);
        SH_LEFT:  shifted = {partial[HALF_W-1:0], {HALF_W{1'b0}}};
        default:  shifted = partial[DATA_W-1:0];
      endcase
    end
  end

  always_comb begin
    total     = {1'b0, shifted} + {1'b0, z_in};
    sum_out   = total[DATA_W-1:0];
    carry_out = total[DATA_W];
    ovf_out   = (shifted[DATA_W-1] == z_in[DATA_W-1]) &&
                (total[DATA_W-1] != shifted[DATA_W-1]);
  end

endmodule

// File: rtl/add3_out_stage.sv
module add3_out_stage
  import add3_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              cc_en,
  input  logic [DATA_W-1:0] sum_in,
  input  logic              carry_in,
  input  logic              ovf_in,
  output logic [DATA_W-1:0] result_q,
  output cond_flags_t       flags_q,
  output logic              valid_q
);

  logic [DATA_W-1:0] result_d;
  cond_flags_t       flags_d;
  cond_flags_t       flags_new;
  logic              res_en;
  logic              flg_en;

  always_comb begin
    flags_new.zero  = (sum_in == '0);
    flags_new.sign  = sum_in[DATA_W-1];
    flags_new.carry = carry_in;
    flags_new.ovf   = ovf_in;
    res_en   = in_valid;
    flg_en   = in_valid && cc_en;
    result_d = res_en ? sum_in : result_q;
    flags_d  = flg_en ? flags_new : flags_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result_q <= '0;
      flags_q  <= '0;
      valid_q  <= 1'b0;
    end else begin
      result_q <= result_d;
      flags_q  <= flags_d;
      valid_q  <= in_valid;
    end
  end

endmodule

// File: rtl/add3_unit.sv
module add3_unit
  import add3_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] op_a,
  input  logic [DATA_W-1:0] op_b,
  input  logic [DATA_W-1:0] op_c,
  input  logic              neg_a,
  input  logic              neg_b,
  input  logic              neg_c,
  input  logic [1:0]        height_a,
  input  logic [1:0]        height_b,
  input  logic [1:0]        height_c,
  input  logic [1:0]        shift_mode,
  input  logic              reg_form,
  input  logic              cc_en,
  output logic              out_valid,
  output logic [DATA_W-1:0] result,
  output logic              flag_zero,
  output logic              flag_sign,
  output logic              flag_carry,
  output logic              flag_ovf
);

  logic [NUM_OPND-1:0][DATA_W-1:0] raw_opnd;
  logic [NUM_OPND-1:0][DATA_W-1:0] prep_opnd;
  logic [NUM_OPND-1:0][1:0]        height_v;
  logic [NUM_OPND-1:0]             neg_v;
  logic [DATA_W-1:0]               sum_w;
  logic                            carry_w;
  logic                            ovf_w;
  cond_flags_t                     flags_w;

  always_comb begin
    raw_opnd = {op_c, op_b, op_a};
    height_v = {height_c, height_b, height_a};
    neg_v    = {neg_c, neg_b, neg_a};
  end

  for (genvar gi = 0; gi < NUM_OPND; gi++) begin : g_prep
    add3_operand_prep #(.DATA_W(DATA_W)) i_prep (
      .opnd     (raw_opnd[gi]),
      .height   (height_v[gi]),
      .neg      (neg_v[gi]),
      .reg_form (reg_form),
      .prepped  (prep_opnd[gi])
    );
  end

  add3_sum_core #(.DATA_W(DATA_W)) i_core (
    .x_in       (prep_opnd[0]),
    .y_in       (prep_opnd[1]),
    .z_in       (prep_opnd[2]),
    .shift_mode (shift_mode),
    .reg_form   (reg_form),
    .sum_out    (sum_w),
    .carry_out  (carry_w),
    .ovf_out    (ovf_w)
  );

  add3_out_stage #(.DATA_W(DATA_W)) i_out (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .cc_en    (cc_en),
    .sum_in   (sum_w),
    .carry_in (carry_w),
    .ovf_in   (ovf_w),
    .result_q (result),
    .flags_q  (flags_w),
    .valid_q  (out_valid)
  );

  always_comb begin
    flag_zero  = flags_w.zero;
    flag_sign  = flags_w.sign;
    flag_carry = flags_w.carry;
    flag_ovf   = flags_w.ovf;
  end

endmodule

// File: rtl/add3_unit_chk.sv
module add3_unit_chk #(
  parameter int unsigned DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              reg_form,
  input logic              cc_en,
  input logic [DATA_W-1:0] op_a,
  input logic [DATA_W-1:0] op_b,
  input logic [DATA_W-1:0] op_c,
  input logic              neg_a,
  input logic              neg_b,
  input logic              neg_c,
  input logic              out_valid,
  input logic [DATA_W-1:0] result,
  input logic              flag_zero,
  input logic              flag_sign,
  input logic              flag_carry,
  input logic              flag_ovf
);

  logic [DATA_W-1:0] ca, cb, cc, plain_sum;
  logic [3:0]        flag_vec;

  always_comb begin
    ca        = neg_a ? ('0 - op_a) : op_a;
    cb        = neg_b ? ('0 - op_b) : op_b;
    cc        = neg_c ? ('0 - op_c) : op_c;
    plain_sum = ca + cb + cc;
    flag_vec  = {flag_zero, flag_sign, flag_carry, flag_ovf};
  end

  assert_valid_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  assert_valid_drops_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  assert_result_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(result));

  assert_flags_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && cc_en) |=> $stable(flag_vec));

  assert_zero_sign_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && cc_en) |=> (flag_zero == (result == '0)) && (flag_sign == result[DATA_W-1]));

  assert_plain_sum_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !reg_form) |=> result == $past(plain_sum));

endmodule

bind add3_unit add3_unit_chk #(.DATA_W(DATA_W)) i_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .reg_form   (reg_form),
  .cc_en      (cc_en),
  .op_a       (op_a),
  .op_b       (op_b),
  .op_c       (op_c),
  .neg_a      (neg_a),
  .neg_b      (neg_b),
  .neg_c      (neg_c),
  .out_valid  (out_valid),
  .result     (result),
  .flag_zero  (flag_zero),
  .flag_sign  (flag_sign),
  .flag_carry (flag_carry),
  .flag_ovf   (flag_ovf)
);

// File: tb/test_add3_unit.sv
module test_add3_unit;

  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic [31:0] op_a, op_b, op_c;
  logic        neg_a, neg_b, neg_c;
  logic [1:0]  height_a, height_b, height_c;
  logic [1:0]  shift_mode;
  logic        reg_form;
  logic        cc_en;
  logic        out_valid;
  logic [31:0] result;
  logic        flag_zero, flag_sign, flag_carry, flag_ovf;

  int unsigned n_cmp  = 0;
  int unsigned n_fail = 0;
  bit          done   = 0;

  add3_unit i_add3_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .op_a(op_a), .op_b(op_b), .op_c(op_c),
    .neg_a(neg_a), .neg_b(neg_b), .neg_c(neg_c),
    .height_a(height_a), .height_b(height_b), .height_c(height_c),
    .shift_mode(shift_mode), .reg_form(reg_form), .cc_en(cc_en),
    .out_valid(out_valid), .result(result),
    .flag_zero(flag_zero), .flag_sign(flag_sign),
    .flag_carry(flag_carry), .flag_ovf(flag_ovf)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] prep(input logic [31:0] x, input logic [1:0] h,
                                       input logic n, input logic rf);
    logic [31:0] v;
    v = x;
    if (rf && h == 2'd1) v = x & 32'h0000ffff;
    if (rf && h == 2'd2) v = x >> 16;
    if (n) v = 32'd0 - v;
    return v;
  endfunction

  // Returns {ovf, carry, sum[31:0]}
  function automatic logic [33:0] model(input logic [31:0] a, input logic [31:0] b,
                                        input logic [31:0] c, input logic [1:0] m,
                                        input logic rf);
    longint unsigned p, s, t;
    logic [31:0] s32, r32;
    logic ov;
    p = longint'(a) + longint'(b);
    if (rf && m == 2'd1)      s = p >> 16;
    else if (rf && m == 2'd2) s = (p << 16) & 64'hffffffff;
    else                      s = p & 64'hffffffff;
    s32 = s[31:0];
    t   = s + longint'(c);
    r32 = t[31:0];
    ov  = (s32[31] == c[31]) && (r32[31] != s32[31]);
    return {ov, t[32], r32};
  endfunction

  task automatic drive(input logic [31:0] a, input logic [31:0] b, input logic [31:0] c,
                       input logic [2:0] n, input logic [5:0] h, input logic [1:0] m,
                       input logic rf, input logic cc);
    @(negedge clk);
    in_valid = 1'b1;
    op_a = a; op_b = b; op_c = c;
    {neg_c, neg_b, neg_a} = n;
    {height_c, height_b, height_a} = h;
    shift_mode = m; reg_form = rf; cc_en = cc;
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  logic [31:0] pat_a [6];
  logic [31:0] pat_b [6];
  logic [31:0] pat_c [6];

  initial begin
    pat_a = '{32'h0, 32'hffffffff, 32'h80000000, 32'h12345678, 32'h7fffffff, 32'hdead8001};
    pat_b = '{32'h0, 32'h00000001, 32'h80000000, 32'h9abcdef0, 32'h7fffffff, 32'h0000ffff};
    pat_c = '{32'h0, 32'hffffffff, 32'h00000001, 32'h0f0f0f0f, 32'h00000001, 32'hffff0000};
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0;
    op_a = '0; op_b = '0; op_c = '0;
    neg_a = 0; neg_b = 0; neg_c = 0;
    height_a = 0; height_b = 0; height_c = 0;
    shift_mode = 0; reg_form = 0; cc_en = 0;
    repeat (3) @(negedge clk);
    // R1 during reset
    check("R1 valid in reset", {31'd0, out_valid}, 32'd0);
    check("R1 result in reset", result, 32'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 valid after reset", {31'd0, out_valid}, 32'd0);
    check("R1 result after reset", result, 32'd0);
    check("R1 flags after reset", {28'd0, flag_zero, flag_sign, flag_carry, flag_ovf}, 32'd0);

    // Directed: right shift moves partial carry into bit 16 (R6)
    drive(32'h80000000, 32'h80000000, 32'h0, 3'b000, 6'd0, 2'd1, 1'b1, 1'b1);
    @(negedge clk);
    check("R6 right shift carry into bit16", result, 32'h00010000);
    check("R2 valid after request", {31'd0, out_valid}, 32'd1);
    in_valid = 1'b0;
    @(negedge clk);
    check("R2 valid low after idle", {31'd0, out_valid}, 32'd0);
    check("R2 result held", result, 32'h00010000);

    // R10: flags set to zero=1 then a cc_en=0 request must not change them
    drive(32'h5, 32'h0, 32'hfffffffb, 3'b000, 6'd0, 2'd0, 1'b0, 1'b1);
    @(negedge clk);
    check("R8 zero flag set", {28'd0, flag_zero, flag_sign, flag_carry, flag_ovf}, 32'b1010);
    drive(32'h80000000, 32'h0, 32'h0, 3'b000, 6'd0, 2'd0, 1'b0, 1'b0);
    @(negedge clk);
    check("R10 result updates without cc", result, 32'h80000000);
    check("R10 flags held without cc", {28'd0, flag_zero, flag_sign, flag_carry, flag_ovf}, 32'b1010);
    idle();

    // Sweep: forms, heights, negates, shift codes, operand patterns
    for (int rf = 0; rf < 2; rf++) begin
      for (int h = 0; h < 64; h++) begin
        for (int n = 0; n < 8; n++) begin
          for (int m = 0; m < 4; m++) begin
            for (int p = 0; p < 6; p++) begin
              logic [31:0] ea, eb, ec;
              logic [33:0] exp_v;
              ea = prep(pat_a[p], h[1:0], n[0], rf[0]);
              eb = prep(pat_b[p], h[3:2], n[1], rf[0]);
              ec = prep(pat_c[p], h[5:4], n[2], rf[0]);
              exp_v = model(ea, eb, ec, m[1:0], rf[0]);
              drive(pat_a[p], pat_b[p], pat_c[p], n[2:0], h[5:0], m[1:0], rf[0], 1'b1);
              @(negedge clk);
              if (rf != 0)
                check("R3 R5 R6 result", result, exp_v[31:0]);
              else
                check("R4 R5 R7 result", result, exp_v[31:0]);
              check("R8 R9 flags", {28'd0, flag_zero, flag_sign, flag_carry, flag_ovf},
                    {28'd0, exp_v[31:0] == 32'd0, exp_v[31], exp_v[32], exp_v[33]});
            end
          end
        end
      end
    end
    idle();
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
      $finish;
    end
  end

endmodule